// File: doc/BRIEF.md
# Capture-Compare Timer with Infrared Carrier Modulation

This block is a 16-bit up-counting timer with five channels. Each channel either drives a pulse-width output from a compare value or records the count when an edge arrives on its input. The main counter runs from a selectable clock divider and wraps to zero after it reaches a programmable period. A second, 8-bit carrier timer runs alongside it. The carrier timer has its own divider, period and compare value, and it produces a square-ish carrier waveform.

In infrared mode the main counter no longer uses its divider. It advances once each time the carrier timer completes a period. Every compare output is then gated by the carrier waveform. The channel outputs become modulated bursts whose envelope is set by the main period and compare values. A flat write port loads the configuration. Period and compare updates are held in shadow registers so that a running waveform never glitches. Each channel raises a sticky event flag, and software clears the flag by writing a one to its bit.

Top module: `ccp_ir_timer`

## Requirements
- R1: Control register (address 0): bits[1:0] select the main divider with codes 0,1,2,3 meaning divide by 1,8,32,128; bit2 is run; bit3 is infrared mode; bits[5:4] select the carrier divider with the same coding. While run is set and infrared mode is clear, the main count advances once every divider-length group of clock cycles, starting from the cycle after run is set.
- R2: After the count reaches the active period, the next advance returns it to zero.
- R3: A channel in compare mode drives its output high while count < active compare and low otherwise.
- R4: A channel in compare mode sets its flag when the count advances away from a value equal to its active compare. Writing address 14 clears flag i for each data bit i that is one. Flags otherwise stay set.
- R5: Addresses 1 (period) and 2..6 (compare for channels 0..4) write shadow registers. While running, a shadow value becomes active only when the count wraps. While stopped, it becomes active on the next cycle.
- R6: Addresses 7..11 configure channels 0..4. Bit0=1 selects capture mode. Bits[2:1] select the edge: 00 none, 01 rising, 10 falling, 11 both. The input passes through a two-stage synchroniser. On the selected edge, the channel latches the count and sets its flag, and the count latched is the value held two cycles after the input changes. A channel in capture mode drives its output low.
- R7: The carrier timer counts up on its divided clock and wraps to zero after reaching its period (address 12, 8 bits). Its output is high while its count < its compare (address 13). Both values load at a carrier wrap or while stopped. While stopped, the carrier count is held at zero.
- R8: In infrared mode the main count advances once per carrier wrap. Every channel output is ANDed with the carrier output.
- R9: While stopped, the main count holds its value. Writing address 15 loads the count directly. After reset the count, flags, channel outputs and captured values are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| cap_in | input | 5 | Per-channel capture inputs (asynchronous) |
| ch_out | output | 5 | Per-channel compare/modulated outputs |
| carrier_out | output | 1 | Carrier timer output |
| flags | output | 5 | Sticky per-channel event flags |
| count | output | 16 | Current main count |
| cap_vals | output | 80 | Captured counts, channel i in bits [16*i+15:16*i] |

## Verification
The assertions check several properties on every cycle:
- The count holds while stopped unless it is loaded.
- No channel output is high while the carrier is low in infrared mode.
- A capture-mode channel never drives its output.
- Flags stay set until cleared.
- The carrier count sits at zero while stopped.

Only the bench scenarios can show the arithmetic of the timer:
- Divider ratios and wrap points.
- Pulse-width levels at chosen counts.
- The count of carrier periods seen in infrared mode.
- Deferred shadow loading.
- The exact count latched by a capture.
- That unselected edges leave the flag and the captured value untouched.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  localparam int PRE_W = 7;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e edge_sel;
    logic      cap_mode;
  } ch_cfg_t;

  typedef struct packed {
    logic [1:0] car_div;
    logic       ir_en;
    logic       run;
    logic [1:0] main_div;
  } ctl_t;

  function automatic logic [PRE_W-1:0] div_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    div_limit = PRE_W'(0);
      2'd1:    div_limit = PRE_W'(7);
      2'd2:    div_limit = PRE_W'(31);
      default: div_limit = PRE_W'(127);
    endcase
  endfunction

endpackage

// File: rtl/ccp_rst_sync.sv
module ccp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ccp_prescaler.sv
module ccp_prescaler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);
  import ccp_pkg::*;

  logic [PRE_W-1:0] cnt_q, cnt_d, lim;

  assign lim  = div_limit(sel);
  assign tick = en && (cnt_q >= lim);

  always_comb begin
    if (!en)              cnt_d = '0;
    else if (cnt_q >= lim) cnt_d = '0;
    else                  cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ccp_carrier.sv
module ccp_carrier #(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       div_sel,
  input  logic [CAR_W-1:0] per_sh,
  input  logic [CAR_W-1:0] cmp_sh,
  output logic             wrap,
  output logic             car_out,
  output logic [CAR_W-1:0] car_cnt
);
  logic             tick;
  logic [CAR_W-1:0] cnt_q, cnt_d, per_q, per_d, cmp_q, cmp_d;

  ccp_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .sel  (div_sel),
    .tick (tick)
  );

  assign wrap    = run && tick && (cnt_q >= per_q);
  assign car_out = (cnt_q < cmp_q);
  assign car_cnt = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    cmp_d = cmp_q;
    if (!run) begin
      cnt_d = '0;
      per_d = per_sh;
      cmp_d = cmp_sh;
    end else if (tick) begin
      if (cnt_q >= per_q) begin
        cnt_d = '0;
        per_d = per_sh;
        cmp_d = cmp_sh;
      end else begin
        cnt_d = cnt_q + CAR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      cmp_q <= cmp_d;
    end
  end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ccp_pkg::ch_cfg_t cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_sh,
  input  logic             load,
  input  logic             adv,
  input  logic             ir_mode,
  input  logic             car_out,
  input  logic             cap_in,
  input  logic             clr,
  output logic             out,
  output logic             flag,
  output logic [CNT_W-1:0] cap_val
);
  import ccp_pkg::*;

  logic [2:0]       sync_q, sync_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, cap_q, cap_d;
  logic             flag_q, flag_d;
  logic             rise, fall, hit, cmp_evt;

  // stage 0 and 1 synchronise, stage 2 holds the previous synchronised level
  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];

  always_comb begin
    hit = 1'b0;
    if (cfg.cap_mode) begin
      case (cfg.edge_sel)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  assign cmp_evt = !cfg.cap_mode && adv && (cnt == cmp_q);

  always_comb begin
    sync_d = {sync_q[1:0], cap_in};
    cmp_d  = load ? cmp_sh : cmp_q;
    cap_d  = hit ? cnt : cap_q;
    flag_d = (flag_q & ~clr) | hit | cmp_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cmp_q  <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cmp_q  <= cmp_d;
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign out     = !cfg.cap_mode && (cnt < cmp_q) && (!ir_mode || car_out);
  assign flag    = flag_q;
  assign cap_val = cap_q;
endmodule

// File: rtl/ccp_ir_timer.sv
module ccp_ir_timer #(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int CAR_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CNT_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]       cap_in,
  output logic [NUM_CH-1:0]       ch_out,
  output logic                    carrier_out,
  output logic [NUM_CH-1:0]       flags,
  output logic [CNT_W-1:0]        count,
  output logic [NUM_CH*CNT_W-1:0] cap_vals
);
  import ccp_pkg::*;

  localparam int A_CTL   = 0;
  localparam int A_PER   = 1;
  localparam int A_CMP0  = 2;
  localparam int A_CFG0  = A_CMP0 + NUM_CH;
  localparam int A_CPER  = A_CFG0 + NUM_CH;
  localparam int A_CCMP  = A_CPER + 1;
  localparam int A_FCLR  = A_CPER + 2;
  localparam int A_CLOAD = A_CPER + 3;

  logic              rst_sync_n;
  ctl_t              ctl_q, ctl_d;
  logic [CNT_W-1:0]  per_sh_q, per_sh_d, per_q, per_d, cnt_q, cnt_d;
  logic [CNT_W-1:0]  cmp_sh_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_sh_d [NUM_CH];
  ch_cfg_t           cfg_q [NUM_CH];
  ch_cfg_t           cfg_d [NUM_CH];
  logic [CAR_W-1:0]  cper_q, cper_d, ccmp_q, ccmp_d, car_cnt;
  logic [NUM_CH-1:0] clr_vec, cap_mask;
  logic [CNT_W-1:0]  cap_w [NUM_CH];
  logic              main_tick, car_wrap, car_out, adv, at_top, wrap_load, cnt_ld;

  ccp_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  ccp_prescaler u_main_pre (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .en   (ctl_q.run && !ctl_q.ir_en),
    .sel  (ctl_q.main_div),
    .tick (main_tick)
  );

  ccp_carrier #(.CAR_W(CAR_W)) u_car (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (ctl_q.run),
    .div_sel(ctl_q.car_div),
    .per_sh (cper_q),
    .cmp_sh (ccmp_q),
    .wrap   (car_wrap),
    .car_out(car_out),
    .car_cnt(car_cnt)
  );

  // register write port: next-state logic
  always_comb begin
    ctl_d    = ctl_q;
    per_sh_d = per_sh_q;
    cper_d   = cper_q;
    ccmp_d   = ccmp_q;
    clr_vec  = '0;
    cnt_ld   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      cmp_sh_d[i] = cmp_sh_q[i];
      cfg_d[i]    = cfg_q[i];
    end
    if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTL))   ctl_d    = ctl_t'(wr_data[5:0]);
      if (wr_addr == ADDR_W'(A_PER))   per_sh_d = wr_data;
      if (wr_addr == ADDR_W'(A_CPER))  cper_d   = wr_data[CAR_W-1:0];
      if (wr_addr == ADDR_W'(A_CCMP))  ccmp_d   = wr_data[CAR_W-1:0];
      if (wr_addr == ADDR_W'(A_FCLR))  clr_vec  = wr_data[NUM_CH-1:0];
      if (wr_addr == ADDR_W'(A_CLOAD)) cnt_ld   = 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_addr == ADDR_W'(A_CMP0 + i)) cmp_sh_d[i] = wr_data;
        if (wr_addr == ADDR_W'(A_CFG0 + i)) cfg_d[i]    = ch_cfg_t'(wr_data[2:0]);
      end
    end
  end

  // main counter: next-state logic
  assign adv       = ctl_q.run && (ctl_q.ir_en ? car_wrap : main_tick);
  assign at_top    = (cnt_q >= per_q);
  assign wrap_load = !ctl_q.run || (adv && at_top);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_ld)   cnt_d = wr_data;
    else if (adv) cnt_d = at_top ? '0 : cnt_q + CNT_W'(1);
    per_d = wrap_load ? per_sh_q : per_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q    <= '0;
      per_sh_q <= '0;
      per_q    <= '0;
      cnt_q    <= '0;
      cper_q   <= '0;
      ccmp_q   <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        cmp_sh_q[i] <= '0;
        cfg_q[i]    <= '0;
      end
    end else begin
      ctl_q    <= ctl_d;
      per_sh_q <= per_sh_d;
      per_q    <= per_d;
      cnt_q    <= cnt_d;
      cper_q   <= cper_d;
      ccmp_q   <= ccmp_d;
      for (int i = 0; i < NUM_CH; i++) begin
        cmp_sh_q[i] <= cmp_sh_d[i];
        cfg_q[i]    <= cfg_d[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ccp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .cfg    (cfg_q[g]),
      .cnt    (cnt_q),
      .cmp_sh (cmp_sh_q[g]),
      .load   (wrap_load),
      .adv    (adv),
      .ir_mode(ctl_q.ir_en),
      .car_out(car_out),
      .cap_in (cap_in[g]),
      .clr    (clr_vec[g]),
      .out    (ch_out[g]),
      .flag   (flags[g]),
      .cap_val(cap_w[g])
    );
    assign cap_vals[g*CNT_W +: CNT_W] = cap_w[g];
    assign cap_mask[g]                = cfg_q[g].cap_mode;
  end

  assign carrier_out = car_out;
  assign count       = cnt_q;
endmodule

// File: rtl/ccp_ir_timer_chk.sv
module ccp_ir_timer_chk #(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int CAR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              ir,
  input logic              car_out,
  input logic              cnt_ld,
  input logic [NUM_CH-1:0] ch_out,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] clr_vec,
  input logic [NUM_CH-1:0] cap_mask,
  input logic [CNT_W-1:0]  cnt,
  input logic [CAR_W-1:0]  car_cnt
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> $stable(cnt));

  assert_ir_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ir && !car_out) |-> (ch_out == '0));

  assert_capture_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_out & cap_mask) == '0));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~clr_vec) != '0) |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec)));

  assert_car_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (car_cnt == '0));
endmodule

bind ccp_ir_timer ccp_ir_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CAR_W(CAR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .run     (ctl_q.run),
  .ir      (ctl_q.ir_en),
  .car_out (car_out),
  .cnt_ld  (cnt_ld),
  .ch_out  (ch_out),
  .flags   (flags),
  .clr_vec (clr_vec),
  .cap_mask(cap_mask),
  .cnt     (cnt_q),
  .car_cnt (car_cnt)
);

// File: tb/ccp_ir_timer_test.sv
module ccp_ir_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTL = 4'd0, A_PER = 4'd1, A_CMP0 = 4'd2, A_CFG0 = 4'd7,
                         A_CPER = 4'd12, A_CCMP = 4'd13, A_FCLR = 4'd14, A_CLOAD = 4'd15;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] cmp;
    logic [1:0]  mdiv;
    logic        ir;
    logic [7:0]  cp;
    logic [7:0]  cc;
    logic [1:0]  cdiv;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{16'd9,   16'd4,  2'd0, 1'b0, 8'd3, 8'd2, 2'd0, 16'd3},
    '{16'd9,   16'd4,  2'd0, 1'b0, 8'd3, 8'd2, 2'd0, 16'd7},
    '{16'd9,   16'd4,  2'd0, 1'b0, 8'd3, 8'd2, 2'd0, 16'd12},
    '{16'd20,  16'd10, 2'd1, 1'b0, 8'd3, 8'd2, 2'd0, 16'd50},
    '{16'd100, 16'd3,  2'd2, 1'b0, 8'd3, 8'd2, 2'd0, 16'd130},
    '{16'd5,   16'd2,  2'd3, 1'b0, 8'd3, 8'd2, 2'd0, 16'd300},
    '{16'd9,   16'd5,  2'd0, 1'b1, 8'd3, 8'd2, 2'd0, 16'd9},
    '{16'd9,   16'd5,  2'd0, 1'b1, 8'd3, 8'd2, 2'd0, 16'd10},
    '{16'd9,   16'd5,  2'd0, 1'b1, 8'd1, 8'd1, 2'd1, 16'd40},
    '{16'd9,   16'd5,  2'd0, 1'b1, 8'd1, 8'd1, 2'd1, 16'd35},
    '{16'd2,   16'd1,  2'd0, 1'b1, 8'd4, 8'd3, 2'd0, 16'd37}
  };

  logic        clk, rst_n, wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [4:0]  cap_in, ch_out, flags;
  logic        carrier_out;
  logic [15:0] count;
  logic [79:0] cap_vals;
  int          n_chk, n_bad;
  bit          done;

  ccp_ir_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_in(cap_in), .ch_out(ch_out), .carrier_out(carrier_out), .flags(flags),
    .count(count), .cap_vals(cap_vals)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400 && !ok; k++) begin
      @(negedge clk);
      if (count == v) ok = 1'b1;
    end
  endtask

  function automatic int divof(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 32;
      default: return 128;
    endcase
  endfunction

  function automatic logic [15:0] ctlw(input logic [1:0] cdiv, input logic ir,
                                       input logic run, input logic [1:0] mdiv);
    return {10'd0, cdiv, ir, run, mdiv};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    int exp_cap, mx, old_cap;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cap_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R9 reset state
    check("R9 reset count", int'(count), 0);
    check("R9 reset flags", int'(flags), 0);
    check("R9 reset outputs", int'(ch_out), 0);
    check("R9 reset captures", int'(cap_vals != '0), 0);

    // table walk: R1 divider, R2 wrap, R3 level, R7 carrier, R8 infrared
    for (int i = 0; i < 11; i++) begin
      vec_t v;
      int ticks, cticks, ccnt, ecnt, ecar, ech;
      v = VECS[i];
      wr(A_CTL, 16'd0);
      wr(A_CLOAD, 16'd0);
      wr(A_PER, v.per);
      wr(A_CMP0, v.cmp);
      wr(A_CPER, {8'd0, v.cp});
      wr(A_CCMP, {8'd0, v.cc});
      wr(A_CTL, ctlw(v.cdiv, v.ir, 1'b1, v.mdiv));
      repeat (int'(v.n)) @(posedge clk);
      @(negedge clk);
      cticks = int'(v.n) / divof(v.cdiv);
      ccnt   = cticks % (int'(v.cp) + 1);
      ecar   = (ccnt < int'(v.cc)) ? 1 : 0;
      ticks  = v.ir ? cticks / (int'(v.cp) + 1) : int'(v.n) / divof(v.mdiv);
      ecnt   = ticks % (int'(v.per) + 1);
      ech    = ((ecnt < int'(v.cmp)) && (!v.ir || ecar == 1)) ? 1 : 0;
      check(v.ir ? "R8 infrared count" : "R1 R2 count", int'(count), ecnt);
      check("R7 carrier level", int'(carrier_out), ecar);
      check(v.ir ? "R8 gated output" : "R3 compare level", int'(ch_out[0]), ech);
    end

    // R7: stopped carrier count sits at zero, so output = (0 < compare)
    wr(A_CTL, 16'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 stopped carrier", int'(carrier_out), 1);

    // R4 compare flag and clear
    wr(A_CLOAD, 16'd0);
    wr(A_PER, 16'd9);
    wr(A_CMP0, 16'd3);
    wr(A_FCLR, 16'h001F);
    wr(A_CTL, ctlw(2'd0, 1'b0, 1'b1, 2'd0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 flag before leaving compare", int'(flags[0]), 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 flag after leaving compare", int'(flags[0]), 1);
    wr(A_FCLR, 16'h0001);
    @(negedge clk);
    check("R4 flag cleared", int'(flags[0]), 0);

    // R5 compare shadow
    wr(A_CTL, 16'd0);
    wr(A_CLOAD, 16'd0);
    wr(A_CMP0, 16'd5);
    wr(A_CTL, ctlw(2'd0, 1'b0, 1'b1, 2'd0));
    wait_cnt(16'd2, ok);
    wr(A_CMP0, 16'd1);
    wait_cnt(16'd4, ok);
    check("R5 old compare kept", int'(ch_out[0]), 1);
    wait_cnt(16'd0, ok);
    wait_cnt(16'd2, ok);
    check("R5 new compare at wrap", int'(ch_out[0]), 0);

    // R5 period shadow
    wait_cnt(16'd3, ok);
    wr(A_PER, 16'd3);
    wait_cnt(16'd9, ok);
    check("R5 old period kept", int'(ok), 1);
    wait_cnt(16'd0, ok);
    mx = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
    end
    check("R5 new period after wrap", mx, 3);

    // R9 hold while stopped, direct load
    wr(A_CTL, 16'd0);
    @(negedge clk);
    mx = int'(count);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 hold while stopped", int'(count), mx);
    wr(A_CLOAD, 16'h0042);
    @(negedge clk);
    check("R9 direct load", int'(count), 16'h42);

    // R6 capture
    wr(A_CLOAD, 16'd0);
    wr(A_PER, 16'd1000);
    wr(A_CMP0 + 4'd1, 16'd500);
    wr(A_CFG0 + 4'd1, 16'h0003);
    wr(A_CFG0 + 4'd2, 16'h0001);
    wr(A_FCLR, 16'h001F);
    wr(A_CTL, ctlw(2'd0, 1'b0, 1'b1, 2'd0));
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R6 capture channel output low", int'(ch_out[1]), 0);
    cap_in[1] = 1'b1;
    cap_in[2] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_cap = int'(count);
    @(posedge clk);
    @(negedge clk);
    check("R6 rising capture value", int'(cap_vals[31:16]), exp_cap);
    check("R6 rising capture flag", int'(flags[1]), 1);
    check("R6 no-edge channel flag", int'(flags[2]), 0);
    wr(A_FCLR, 16'h0002);
    old_cap = int'(cap_vals[31:16]);
    @(negedge clk);
    cap_in[1] = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R6 falling ignored flag", int'(flags[1]), 0);
    check("R6 falling ignored value", int'(cap_vals[31:16]), old_cap);
    wr(A_CFG0 + 4'd1, 16'h0007);
    repeat (2) @(posedge clk);
    @(negedge clk);
    cap_in[1] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_cap = int'(count);
    @(posedge clk);
    @(negedge clk);
    check("R6 both-edge rising value", int'(cap_vals[31:16]), exp_cap);
    cap_in[1] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_cap = int'(count);
    @(posedge clk);
    @(negedge clk);
    check("R6 both-edge falling value", int'(cap_vals[31:16]), exp_cap);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule